// File: doc/BRIEF.md
# Slot Timer with Tunable Prescaler

This block measures protocol time slots for a radio MAC layer. A tick-enable input, already divided down from the system clock, feeds an 18-bit prescaler. The top byte of the prescaler is a programmable ceiling. A 2-bit interval code sets how fast the prescaler climbs toward that ceiling. Each time the prescaler reaches the ceiling it restarts from zero and emits a slot pulse. Every slot pulse decrements an 8-bit down-counter.

When the counter reaches zero, the block raises a sticky expiry flag and emits a one-cycle DMA trigger. It can also raise a pending-interrupt flag. Software reaches the control, count and prescale registers through a small register bus. This bus has an address, a write enable, write data and combinational read data. An interrupt request leaves the block only when the local enable bit and a global timer interrupt enable input are both set.

Top module: `slot_timer`

## Requirements
- R1: After reset, all three registers read 0x00, and `irq_o` and `dma_trig_o` are low.
- R2: The interval code (control bits [1:0]) selects a multiplier: 00 gives 64, 01 gives 128, 10 gives 256 and 11 gives 1024. With a nonzero prescale value P, the count decrements on the tick that completes every P × multiplier ticks.
- R3: The register addresses are: 0 for control, 1 for count and 2 for prescale value. The control byte layout is: [1:0] interval code, [2] wrap enable, [3] interrupt enable, [5:4] read as 0, [6] expiry flag, [7] pending flag. Written fields read back unchanged.
- R4: Each slot pulse decrements the count by one. Apart from a software write, the count changes only in this way.
- R5: A slot pulse that takes the count to 0x00 sets the expiry flag. With wrap enable at 0, the count then stays at 0x00 on later slot pulses.
- R6: With wrap enable at 1, a slot pulse at count 0x00 loads 0xFF and does not set the expiry flag.
- R7: The pending flag is set together with the expiry flag only when the interrupt-enable bit is 1. `irq_o` equals pending flag AND interrupt-enable bit AND `gie_i`.
- R8: `dma_trig_o` is high for exactly the one cycle after each clock edge where an expiry event occurs.
- R9: A write to the count takes effect at the next edge. If a slot pulse lands in the same cycle, the stored value is the written value minus one, and reaching 0x00 this way sets the expiry flag.
- R10: Writing 0 to a flag bit clears that flag. Writing 1 to it has no effect. An expiry event in the same cycle wins over the clear.
- R11: A prescale value of 0 stops slot pulses and holds the prescaler at zero on each tick.
- R12: Without `tick_i`, neither the prescaler nor the count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable, one cycle per tick |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Register write enable |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| gie_i | input | 1 | Global timer interrupt enable |
| irq_o | output | 1 | Interrupt request |
| dma_trig_o | output | 1 | One-cycle DMA trigger on expiry |

## Verification
A register write and a closing tick both act at the same clock edge. The new count and flags appear on `rdata_o` and `irq_o` in the cycle that follows that edge, and `dma_trig_o` is high only during that one cycle. The bench drives each cycle's inputs after the falling edge. It compares every output one nanosecond later, before the next rising edge, against a reference model. The model advances once per rising edge. Directed runs count out exactly P × multiplier − 1 ticks. They confirm the count is unchanged at that point and then check it one tick later, so an off-by-one in the prescaler shows up.

// File: rtl/slot_timer_pkg.sv
`timescale 1ns/1ps
package slot_timer_pkg;
  typedef enum logic [1:0] {
    REG_CTL = 2'd0,
    REG_CNT = 2'd1,
    REG_PRE = 2'd2
  } reg_sel_e;

  localparam int unsigned CTL_WRAP = 2;
  localparam int unsigned CTL_IE   = 3;
  localparam int unsigned CTL_EXP  = 6;
  localparam int unsigned CTL_PEND = 7;
  localparam int unsigned FRAC_W   = 10;  // log2 of the largest multiplier

  // prescaler increment per tick = 1024 / multiplier
  function automatic logic [FRAC_W:0] step_of(input logic [1:0] code);
    case (code)
      2'b00:   return (FRAC_W+1)'(16);
      2'b01:   return (FRAC_W+1)'(8);
      2'b10:   return (FRAC_W+1)'(4);
      default: return (FRAC_W+1)'(1);
    endcase
  endfunction
endpackage

// File: rtl/slot_prescaler.sv
`timescale 1ns/1ps
module slot_prescaler
  import slot_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 18,
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       code_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             slot_o
);
  localparam int unsigned LOW_W = PRE_W - LIM_W;

  logic [PRE_W-1:0] acc_q;
  logic [PRE_W:0]   sum, ceil_w;
  logic             run, hit;

  always_comb begin
    ceil_w = {1'b0, limit_i, {LOW_W{1'b0}}};
    sum    = {1'b0, acc_q} + (PRE_W+1)'(step_of(code_i));
    run    = (limit_i != '0);
    hit    = run && (sum >= ceil_w);
    slot_o = tick_i && hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= (hit || !run) ? '0 : sum[PRE_W-1:0];
  end
endmodule

// File: rtl/slot_down_counter.sv
`timescale 1ns/1ps
module slot_down_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         slot_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wrap_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, base, nxt;

  always_comb begin
    base = wr_i ? wdata_i : cnt_q;   // written value still sees a colliding slot
    nxt  = base;
    if (slot_i) begin
      if (base == '0) nxt = wrap_i ? '1 : '0;
      else            nxt = base - W'(1);
    end
    expire_o = slot_i && (base == W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/slot_timer.sv
`timescale 1ns/1ps
module slot_timer
  import slot_timer_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned PRE_W = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          gie_i,
  output logic          irq_o,
  output logic          dma_trig_o
);
  logic [1:0]    code_q;
  logic          wrap_q, ie_q, exp_q, pend_q, dma_q;
  logic [DW-1:0] pre_q, cnt;
  logic          slot, expire;
  logic          wr_ctl, wr_cnt, wr_pre;

  assign wr_ctl = we_i && (addr_i == REG_CTL);
  assign wr_cnt = we_i && (addr_i == REG_CNT);
  assign wr_pre = we_i && (addr_i == REG_PRE);

  slot_prescaler #(.PRE_W(PRE_W), .LIM_W(DW)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .code_i (code_q),
    .limit_i(pre_q),
    .slot_o (slot)
  );

  slot_down_counter #(.W(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_i  (slot),
    .wr_i    (wr_cnt),
    .wdata_i (wdata_i),
    .wrap_i  (wrap_q),
    .cnt_o   (cnt),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      wrap_q <= 1'b0;
      ie_q   <= 1'b0;
      exp_q  <= 1'b0;
      pend_q <= 1'b0;
      pre_q  <= '0;
      dma_q  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        code_q <= wdata_i[1:0];
        wrap_q <= wdata_i[CTL_WRAP];
        ie_q   <= wdata_i[CTL_IE];
      end
      if (wr_pre) pre_q <= wdata_i;
      // flags: write-0 clears, set event has priority
      exp_q  <= expire | (exp_q & ~(wr_ctl & ~wdata_i[CTL_EXP]));
      pend_q <= (expire & ie_q) | (pend_q & ~(wr_ctl & ~wdata_i[CTL_PEND]));
      dma_q  <= expire;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTL: begin
        rdata_o[1:0]      = code_q;
        rdata_o[CTL_WRAP] = wrap_q;
        rdata_o[CTL_IE]   = ie_q;
        rdata_o[CTL_EXP]  = exp_q;
        rdata_o[CTL_PEND] = pend_q;
      end
      REG_CNT: rdata_o = cnt;
      REG_PRE: rdata_o = pre_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o      = pend_q & ie_q & gie_i;
  assign dma_trig_o = dma_q;
endmodule

// File: rtl/slot_timer_chk.sv
`timescale 1ns/1ps
module slot_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic       gie_i,
  input logic       irq_o,
  input logic       dma_trig_o,
  input logic       ie_q,
  input logic       exp_q,
  input logic       wrap_q,
  input logic       slot,
  input logic [7:0] cnt
);
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_i && ie_q)); // R7
  AST_DMA_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exp_q) |-> dma_trig_o); // R8
  AST_DMA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_trig_o |=> !dma_trig_o); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 2'd1) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 8'd1)); // R4
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_q && cnt == 8'd0 && !(we_i && addr_i == 2'd1)) |=> cnt == 8'd0); // R5
  AST_TICK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !slot); // R12
endmodule

bind slot_timer slot_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .gie_i     (gie_i),
  .irq_o     (irq_o),
  .dma_trig_o(dma_trig_o),
  .ie_q      (ie_q),
  .exp_q     (exp_q),
  .wrap_q    (wrap_q),
  .slot      (slot),
  .cnt       (cnt)
);

// File: tb/tb_slot_timer.sv
`timescale 1ns/1ps
module tb_slot_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       gie = 1'b0;
  logic       irq, dma;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  int       m_acc = 0;
  logic [7:0] m_cnt = 0, m_pr = 0;
  logic [1:0] m_code = 0;
  logic     m_wrap = 0, m_ie = 0, m_exp = 0, m_pend = 0, m_dma = 0;

  always #5 clk = ~clk;

  slot_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .gie_i(gie), .irq_o(irq), .dma_trig_o(dma)
  );

  function automatic int mult_of(input logic [1:0] c);
    case (c) 2'b00: return 64; 2'b01: return 128; 2'b10: return 256; default: return 1024; endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_pend, m_exp, 2'b00, m_ie, m_wrap, m_code};
      2'd1: return m_cnt;
      2'd2: return m_pr;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_update(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
    int step;
    logic slot, evt;
    logic [7:0] base;
    step = 1024 / mult_of(m_code);
    slot = t && (m_pr != 0) && (m_acc + step >= int'(m_pr) * 1024);
    base = (w && a == 2'd1) ? d : m_cnt;
    evt  = slot && base == 8'd1;
    if (t) m_acc = (m_pr == 0 || slot) ? 0 : m_acc + step;
    m_cnt  = slot ? ((base == 0) ? (m_wrap ? 8'hFF : 8'h00) : base - 8'd1) : base;
    m_pend = (evt & m_ie) | (m_pend & ((w && a == 2'd0) ? d[7] : 1'b1));
    m_exp  = evt | (m_exp & ((w && a == 2'd0) ? d[6] : 1'b1));
    m_dma  = evt;
    if (w && a == 2'd0) begin m_code = d[1:0]; m_wrap = d[2]; m_ie = d[3]; end
    if (w && a == 2'd2) m_pr = d;
  endtask

  // one clock cycle; entered and left just after a falling edge
  task automatic cyc(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
    tick = t; we = w; addr = a; wdata = d;
    #1;
    chk(rdata === m_read(a), (a == 2'd1) ? "R4 count" : (a == 2'd0) ? "R10 control" : "R3 prescale",
        rdata, m_read(a));
    chk(irq === (m_pend & m_ie & gie), "R7 irq", irq, m_pend & m_ie & gie);
    chk(dma === m_dma, "R8 dma", dma, m_dma);
    @(posedge clk);
    m_update(t, w, a, d);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic read_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
    tick = 1'b0; we = 1'b0; addr = a;
    #1;
    chk(rdata === e, tag, rdata, e);
    cyc(1'b0, 1'b0, a, 8'h00);
  endtask

  task automatic clr_acc;
    wr(2'd2, 8'h00);
    ticks(1, 2'd1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_exp(2'd0, 8'h00, "R1 ctl reset");
    read_exp(2'd1, 8'h00, "R1 cnt reset");
    read_exp(2'd2, 8'h00, "R1 pre reset");
    chk(irq === 1'b0 && dma === 1'b0, "R1 outputs", {irq, dma}, 0);

    // R3 readback
    wr(2'd2, 8'h2A);
    read_exp(2'd2, 8'h2A, "R3 prescale readback");
    wr(2'd0, 8'h0D);
    read_exp(2'd0, 8'h0D, "R3 control readback");

    // R11 prescale zero stops
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h05);
    wr(2'd2, 8'h00);
    ticks(3000, 2'd1);
    read_exp(2'd1, 8'h05, "R11 no slot at prescale 0");

    // R2 interval per code
    for (int k = 0; k < 4; k++) begin
      clr_acc();
      wr(2'd0, 8'(k));
      wr(2'd1, 8'h03);
      wr(2'd2, 8'h02);
      ticks(2 * mult_of(2'(k)) - 1, 2'd1);
      read_exp(2'd1, 8'h03, "R2 before interval");
      ticks(1, 2'd1);
      read_exp(2'd1, 8'h02, "R2 after interval");
    end

    // R12 no tick, no progress
    clr_acc();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h04);
    wr(2'd2, 8'h01);
    ticks(63, 2'd1);
    repeat (200) cyc(1'b0, 1'b0, 2'd1, 8'h00);
    read_exp(2'd1, 8'h04, "R12 idle without tick");
    ticks(1, 2'd1);
    read_exp(2'd1, 8'h03, "R12 resumes on tick");

    // R5 expiry, R7 irq, R8 dma
    clr_acc();
    gie = 1'b1;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    ticks(64, 2'd1);
    tick = 1'b0; we = 1'b0; addr = 2'd0;
    #1;
    chk(dma === 1'b1, "R8 dma pulse", dma, 1);
    chk(irq === 1'b1, "R7 irq raised", irq, 1);
    chk(rdata === 8'hC8, "R5 expiry flag", rdata, 8'hC8);
    cyc(1'b0, 1'b0, 2'd0, 8'h00);
    #1;
    chk(dma === 1'b0, "R8 dma single cycle", dma, 0);
    ticks(192, 2'd1);
    read_exp(2'd1, 8'h00, "R5 holds at zero");

    // R7 gating
    gie = 1'b0;
    #1;
    chk(irq === 1'b0, "R7 global gate", irq, 0);
    gie = 1'b1;
    wr(2'd0, 8'hC0);
    #1;
    chk(irq === 1'b0, "R7 local gate", irq, 0);

    // R10 flag clear rules
    wr(2'd0, 8'hC8);
    read_exp(2'd0, 8'hC8, "R10 write 1 keeps flags");
    wr(2'd0, 8'h08);
    read_exp(2'd0, 8'h08, "R10 write 0 clears");

    // R6 wrap
    wr(2'd0, 8'h04);
    clr_acc();
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    ticks(64, 2'd1);
    read_exp(2'd1, 8'h00, "R6 reaches zero");
    wr(2'd0, 8'h04);
    ticks(64, 2'd1);
    read_exp(2'd1, 8'hFF, "R6 wraps to FF");
    read_exp(2'd0, 8'h04, "R6 no expiry on wrap");

    // R9 write collides with slot
    wr(2'd0, 8'h00);
    clr_acc();
    wr(2'd2, 8'h01);
    ticks(63, 2'd1);
    cyc(1'b1, 1'b1, 2'd1, 8'h05);
    read_exp(2'd1, 8'h04, "R9 collision minus one");
    ticks(63, 2'd1);
    cyc(1'b1, 1'b1, 2'd1, 8'h01);
    read_exp(2'd1, 8'h00, "R9 collision to zero");
    read_exp(2'd0, 8'h40, "R9 collision expiry");

    // random mix against the model
    for (int i = 0; i < 20000; i++) begin
      int op;
      logic t;
      op = $urandom % 24;
      t  = ($urandom % 4) != 0;
      case (op)
        0: cyc(t, 1'b1, 2'd1, 8'($urandom % 4));
        1: cyc(t, 1'b1, 2'd0, 8'($urandom % 256) & 8'hCF);
        2: cyc(t, 1'b1, 2'd2, 8'(($urandom % 3) + 1));
        3: cyc(t, 1'b1, 2'd2, 8'h00);
        4: begin gie = ~gie; cyc(t, 1'b0, 2'($urandom % 3), 8'h00); end
        default: cyc(t, 1'b0, 2'($urandom % 3), 8'h00);
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule